// File: doc/BRIEF.md
# Private Stack-Top Line Buffer

This block sits inside a processor core and holds the lines at the top of the call stack. It keeps a small set of full 128-bit lines. Loads and stores that the core marks as stack accesses are served from these lines and do not touch the L1 data cache. Stack contents belong to one process only, so the block has no coherence broadcast path. A store to a buffered line stays in the buffer.

A line goes back to L1 in only two cases. The first is when stack activity moves into a line that is not buffered and the line that gets displaced is dirty. The second is a flush, which the core requests when a context switch changes the stack pointer. On a flush every dirty line is written back and then all lines are invalidated.

A miss stalls the core with a ready signal. The block chooses a victim, writes it back if it is dirty, and then fetches the new line from L1. Replacement takes a free line first and otherwise the least recently used one. A per-line dirty flag keeps clean lines from being written back.

The controller has five states:
- ST_IDLE serves hits.
- ST_EVICT writes back a dirty victim.
- ST_FILL fetches the missing line.
- ST_FLUSH walks through the lines and writes back the dirty ones.
- ST_DONE invalidates the buffer and reports completion.

The transitions are:
- ST_IDLE to ST_FLUSH when a flush is requested.
- ST_IDLE to ST_EVICT on a miss with a dirty victim.
- ST_IDLE to ST_FILL on a miss with a clean or invalid victim.
- ST_EVICT to ST_FILL when the write-back is acknowledged.
- ST_FILL to ST_IDLE when the fill data arrives.
- ST_FLUSH to ST_DONE after the last line has been handled.
- ST_DONE to ST_IDLE after one cycle.

Top module: `stack_line_buffer`

## Requirements
- R1: After reset, core_ready is 1 and wb_valid, fill_req and flush_done are 0. All lines are invalid.
- R2: A stack-tagged request that hits is served in the same cycle with core_ready at 1. A read returns the buffered word selected by address bits [3:2], and word n occupies line bits [32n+31:32n]. A hit causes no L1 traffic.
- R3: On a store hit, byte b of the addressed word is replaced with core_wdata[8b+7:8b] only where core_be[b] is 1. All other bytes keep their value.
- R4: On a miss the victim is the lowest-numbered invalid line if one exists. Otherwise it is the least recently used line, where a line counts as used when a request is served from it.
- R5: A dirty victim is presented on wb_valid with wb_addr equal to its line address (address bits [31:4]). It is held until wb_ack. fill_req is raised only after that, never in the same cycle.
- R6: A clean victim is replaced without any write-back.
- R7: Stores to buffered lines are never propagated to L1 apart from displacement and flush.
- R8: A flush writes back every dirty line and then invalidates the whole buffer. flush_done is then 1 for exactly one cycle, even when no line was dirty. Afterwards every stack access misses until it is refilled.
- R9: A flush request takes priority over a core request in the same cycle. core_ready is 0 while flush_req is 1, and the held request is served after the flush.
- R10: A request with core_stack at 0 is acknowledged with core_ready at 1. It changes no buffered data and starts no L1 transfer.
- R11: While a miss is in progress (wb_valid or fill_req at 1), core_ready is 0. fill_req and fill_addr are held until fill_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core access request, held until core_ready |
| core_we | input | 1 | 1 for a store, 0 for a load |
| core_stack | input | 1 | Request is a stack access |
| core_addr | input | 32 | Byte address |
| core_be | input | 4 | Byte enables for a store |
| core_wdata | input | 32 | Store data |
| core_rdata | output | 32 | Load data, valid while core_ready and core_req are 1 |
| core_ready | output | 1 | Request accepted this cycle |
| wb_valid | output | 1 | Line write-back to L1 pending |
| wb_addr | output | 28 | Line address of the write-back |
| wb_data | output | 128 | Line contents being written back |
| wb_ack | input | 1 | L1 has taken the write-back |
| fill_req | output | 1 | Line fetch from L1 pending |
| fill_addr | output | 28 | Line address being fetched |
| fill_data | input | 128 | Fetched line |
| fill_valid | input | 1 | fill_data is valid |
| flush_req | input | 1 | Context-switch flush request, one-cycle pulse |
| flush_done | output | 1 | Flush has finished |

## Verification
The collision that matters is a flush request arriving in the same cycle as a stack load to a dirty line. The bench provokes it by raising both on the same clock edge. It then checks four things. The load must have waited at least one cycle. flush_done must appear. L1 must hold the stored word. The load must return that word after it refills the line from L1. Around this, directed eviction sequences check which line is displaced, and a long random mix of loads, byte-masked stores and flushes is compared against a word-level model of the stack contents.

// File: rtl/slb_pkg.sv
package slb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_FLUSH,
        ST_DONE
    } slb_state_e;
endpackage

// File: rtl/slb_lru.sv
module slb_lru #(
    parameter int NWAYS = 4,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] lru_way
);
    logic [NWAYS-1:0][WAY_W-1:0] age;

    for (genvar w = 0; w < NWAYS; w++) begin : g_age
        logic [WAY_W-1:0] age_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q <= WAY_W'(w);
            end else if (touch) begin
                if (touch_way == WAY_W'(w))
                    age_q <= '0;
                else if (age_q < age[touch_way])
                    age_q <= age_q + 1'b1;
            end
        end
        assign age[w] = age_q;
    end

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < NWAYS; w++)
            if (age[w] == WAY_W'(NWAYS - 1)) lru_way = WAY_W'(w);
    end
endmodule

// File: rtl/slb_store.sv
module slb_store #(
    parameter int NWAYS  = 4,
    parameter int LINE_W = 128,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 28,
    localparam int WAY_W  = $clog2(NWAYS),
    localparam int WSEL_W = $clog2(LINE_W / DATA_W),
    localparam int BE_W   = DATA_W / 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [WSEL_W-1:0]             wr_word,
    input  logic [BE_W-1:0]               wr_be,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          fill_en,
    input  logic [WAY_W-1:0]              fill_way,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [LINE_W-1:0]             fill_line,
    input  logic                          clean_en,
    input  logic [WAY_W-1:0]              clean_way,
    input  logic                          inv_all,
    output logic [NWAYS-1:0]              valid,
    output logic [NWAYS-1:0]              dirty,
    output logic [NWAYS-1:0][TAG_W-1:0]   tag,
    output logic [NWAYS-1:0][LINE_W-1:0]  line
);
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic              v_q, d_q;
        logic [TAG_W-1:0]  t_q;
        logic [LINE_W-1:0] l_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
                l_q <= '0;
            end else if (inv_all) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (fill_en && fill_way == WAY_W'(w)) begin
                v_q <= 1'b1;
                d_q <= 1'b0;
                t_q <= fill_tag;
                l_q <= fill_line;
            end else begin
                if (clean_en && clean_way == WAY_W'(w)) d_q <= 1'b0;
                if (wr_en && wr_way == WAY_W'(w)) begin
                    d_q <= 1'b1;
                    for (int b = 0; b < BE_W; b++)
                        if (wr_be[b])
                            l_q[int'(wr_word)*DATA_W + b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
        assign valid[w] = v_q;
        assign dirty[w] = d_q;
        assign tag[w]   = t_q;
        assign line[w]  = l_q;
    end
endmodule

// File: rtl/stack_line_buffer.sv
module stack_line_buffer
    import slb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINE_W = 128,
    parameter int NWAYS  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          core_req,
    input  logic                          core_we,
    input  logic                          core_stack,
    input  logic [ADDR_W-1:0]             core_addr,
    input  logic [DATA_W/8-1:0]           core_be,
    input  logic [DATA_W-1:0]             core_wdata,
    output logic [DATA_W-1:0]             core_rdata,
    output logic                          core_ready,
    output logic                          wb_valid,
    output logic [ADDR_W-$clog2(LINE_W/8)-1:0] wb_addr,
    output logic [LINE_W-1:0]             wb_data,
    input  logic                          wb_ack,
    output logic                          fill_req,
    output logic [ADDR_W-$clog2(LINE_W/8)-1:0] fill_addr,
    input  logic [LINE_W-1:0]             fill_data,
    input  logic                          fill_valid,
    input  logic                          flush_req,
    output logic                          flush_done
);
    localparam int OFF_W  = $clog2(LINE_W / 8);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int WSEL_W = $clog2(LINE_W / DATA_W);
    localparam int WAY_W  = $clog2(NWAYS);

    slb_state_e state_q, state_d;
    logic [WAY_W-1:0] vic_q, fl_idx_q, hit_way, free_way, lru_way, victim;
    logic [TAG_W-1:0] miss_tag_q;
    logic [NWAYS-1:0] valid, dirty, hit_vec;
    logic [NWAYS-1:0][TAG_W-1:0] tag;
    logic [NWAYS-1:0][LINE_W-1:0] line;
    logic have_free, hit_any, acc, idle_ok, serve, fl_need, fl_last;
    logic wr_en, fill_en, clean_en, inv_all;
    logic [TAG_W-1:0] req_tag;
    logic [WSEL_W-1:0] req_word;
    logic [LINE_W-1:0] hit_line;
    logic unused_low;

    assign req_tag    = core_addr[ADDR_W-1:OFF_W];
    assign req_word   = core_addr[OFF_W-1:OFF_W-WSEL_W];
    assign unused_low = ^core_addr[OFF_W-WSEL_W-1:0];

    always_comb begin
        hit_way   = '0;
        free_way  = '0;
        have_free = 1'b0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            hit_vec[w] = valid[w] && (tag[w] == req_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
            if (!valid[w]) begin
                free_way  = WAY_W'(w);
                have_free = 1'b1;
            end
        end
    end

    assign hit_any  = |hit_vec;
    assign victim   = have_free ? free_way : lru_way;
    assign acc      = core_req && core_stack;
    assign idle_ok  = (state_q == ST_IDLE) && !flush_req;
    assign serve    = idle_ok && acc && hit_any;
    assign hit_line = line[hit_way];
    assign fl_need  = valid[fl_idx_q] && dirty[fl_idx_q];
    assign fl_last  = (fl_idx_q == WAY_W'(NWAYS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush_req)
                    state_d = ST_FLUSH;
                else if (acc && !hit_any)
                    state_d = (valid[victim] && dirty[victim]) ? ST_EVICT : ST_FILL;
            end
            ST_EVICT: if (wb_ack) state_d = ST_FILL;
            ST_FILL:  if (fill_valid) state_d = ST_IDLE;
            ST_FLUSH: if (fl_last && (!fl_need || wb_ack)) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // miss and flush bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vic_q      <= '0;
            miss_tag_q <= '0;
            fl_idx_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && !flush_req && acc && !hit_any) begin
                vic_q      <= victim;
                miss_tag_q <= req_tag;
            end
            if (state_q == ST_IDLE)
                fl_idx_q <= '0;
            else if (state_q == ST_FLUSH && (!fl_need || wb_ack))
                fl_idx_q <= fl_idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        core_ready = idle_ok && (!acc || hit_any);
        core_rdata = serve ? hit_line[int'(req_word)*DATA_W +: DATA_W] : '0;
        wb_valid   = 1'b0;
        wb_addr    = '0;
        wb_data    = '0;
        fill_req   = 1'b0;
        fill_addr  = '0;
        flush_done = 1'b0;
        wr_en      = 1'b0;
        fill_en    = 1'b0;
        clean_en   = 1'b0;
        inv_all    = 1'b0;
        unique case (state_q)
            ST_IDLE:  wr_en = serve && core_we;
            ST_EVICT: begin
                wb_valid = 1'b1;
                wb_addr  = tag[vic_q];
                wb_data  = line[vic_q];
            end
            ST_FILL: begin
                fill_req  = 1'b1;
                fill_addr = miss_tag_q;
                fill_en   = fill_valid;
            end
            ST_FLUSH: begin
                wb_valid = fl_need;
                wb_addr  = tag[fl_idx_q];
                wb_data  = line[fl_idx_q];
                clean_en = fl_need && wb_ack;
            end
            ST_DONE: begin
                flush_done = 1'b1;
                inv_all    = 1'b1;
            end
            default: ;
        endcase
    end

    slb_lru #(.NWAYS(NWAYS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (serve),
        .touch_way (hit_way),
        .lru_way   (lru_way)
    );

    slb_store #(
        .NWAYS(NWAYS), .LINE_W(LINE_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_way    (hit_way),
        .wr_word   (req_word),
        .wr_be     (core_be),
        .wr_data   (core_wdata),
        .fill_en   (fill_en),
        .fill_way  (vic_q),
        .fill_tag  (miss_tag_q),
        .fill_line (fill_data),
        .clean_en  (clean_en),
        .clean_way (fl_idx_q),
        .inv_all   (inv_all),
        .valid     (valid),
        .dirty     (dirty),
        .tag       (tag),
        .line      (line)
    );
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int TAG_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_ready,
    input logic             flush_req,
    input logic             flush_done,
    input logic             wb_valid,
    input logic             wb_ack,
    input logic [TAG_W-1:0] wb_addr,
    input logic             fill_req,
    input logic             fill_valid,
    input logic [TAG_W-1:0] fill_addr
);
    assert_wb_before_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && fill_req));

    assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_addr)));

    assert_fill_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

    assert_stall_on_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid || fill_req) |-> !core_ready);

    assert_flush_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !core_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);
endmodule

bind stack_line_buffer slb_checker #(.TAG_W(TAG_W)) u_slb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ready (core_ready),
    .flush_req  (flush_req),
    .flush_done (flush_done),
    .wb_valid   (wb_valid),
    .wb_ack     (wb_ack),
    .wb_addr    (wb_addr),
    .fill_req   (fill_req),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr)
);

// File: tb/stack_line_buffer_bench.sv
module stack_line_buffer_bench;
    localparam logic [31:0] BASE = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 1'b0, core_we = 1'b0, core_stack = 1'b0;
    logic [31:0] core_addr = '0, core_wdata = '0, core_rdata;
    logic [3:0] core_be = '0;
    logic core_ready, wb_valid, wb_ack, fill_req, fill_valid, flush_req, flush_done;
    logic [27:0] wb_addr, fill_addr;
    logic [127:0] wb_data, fill_data;

    logic [127:0] l1 [16];
    logic [31:0] gold [16][4];
    int wb_cnt = 0, fill_cnt = 0, checks = 0, errors = 0;
    logic [27:0] last_wb = '0;

    always #10 clk = ~clk;

    stack_line_buffer u_stack_line_buffer (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_stack(core_stack), .core_addr(core_addr), .core_be(core_be),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ready(core_ready),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_valid(fill_valid), .flush_req(flush_req), .flush_done(flush_done)
    );

    function automatic logic [127:0] gold_line(input int ln);
        return {gold[ln][3], gold[ln][2], gold[ln][1], gold[ln][0]};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // L1 model: one-cycle acknowledge of write-backs and fills
    initial begin
        wb_ack = 1'b0; fill_valid = 1'b0; fill_data = '0;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 4; j++) begin
                gold[i][j] = 32'hA000_0000 + i * 16 + j;
                l1[i][j*32 +: 32] = gold[i][j];
            end
        forever begin
            @(negedge clk);
            if (wb_valid && !wb_ack) begin
                l1[wb_addr[3:0]] = wb_data;
                last_wb = wb_addr;
                wb_cnt++;
                wb_ack = 1'b1;
            end else wb_ack = 1'b0;
            if (fill_req && !fill_valid) begin
                fill_data = l1[fill_addr[3:0]];
                fill_valid = 1'b1;
                fill_cnt++;
            end else fill_valid = 1'b0;
        end
    end

    task automatic acc(input bit we, input bit stk, input int ln, input int wd,
                       input logic [3:0] be, input logic [31:0] wdat,
                       output logic [31:0] rd, output int waitc);
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_stack = stk;
        core_addr = BASE + ln * 16 + wd * 4; core_be = be; core_wdata = wdat;
        #1;
        waitc = 0;
        while (!core_ready && waitc < 1000) begin
            @(negedge clk); #1; waitc++;
        end
        rd = core_rdata;
        @(posedge clk); #1;
        core_req = 1'b0;
        if (stk && we) gold[ln][wd] = merge(gold[ln][wd], wdat, be);
    endtask

    task automatic rd_chk(input int ln, input int wd, input string req, output int waitc);
        logic [31:0] rd;
        acc(1'b0, 1'b1, ln, wd, 4'h0, 32'h0, rd, waitc);
        chk(rd == gold[ln][wd], req, rd, gold[ln][wd]);
    endtask

    task automatic flush(output bit seen);
        seen = 1'b0;
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        for (int i = 0; i < 100 && !seen; i++) begin
            #1; if (flush_done) seen = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int w, wb0, f0;
        bit seen;
        flush_req = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(core_ready && !wb_valid && !fill_req && !flush_done, "R1",
            {core_ready, wb_valid, fill_req, flush_done}, 4'b1000);
        rst_n = 1'b1;

        // R2 / R11: first access misses, then hits without waiting
        rd_chk(0, 1, "R2", w);
        chk(w > 0 && fill_cnt == 1, "R11", w, 1);
        rd_chk(0, 2, "R2", w);
        chk(w == 0 && fill_cnt == 1, "R2", w, 0);

        // R3 byte-enable merge, R7 no propagation
        acc(1'b1, 1'b1, 0, 1, 4'b0101, 32'h1122_3344, rd, w);
        rd_chk(0, 1, "R3", w);
        chk(wb_cnt == 0 && l1[0][63:32] == 32'hA000_0001, "R7", l1[0][63:32], 32'hA000_0001);

        // R10 non-stack store ignored
        f0 = fill_cnt;
        acc(1'b1, 1'b0, 0, 1, 4'hF, 32'hDEAD_BEEF, rd, w);
        chk(w == 0 && fill_cnt == f0 && wb_cnt == 0, "R10", w, 0);
        rd_chk(0, 1, "R10", w);

        // R4 free lines first, then LRU
        for (int i = 1; i < 4; i++) acc(1'b1, 1'b1, i, 0, 4'hF, 32'h5000_0000 + i, rd, w);
        chk(wb_cnt == 0 && fill_cnt == 4, "R4", wb_cnt, 0);
        rd_chk(0, 0, "R4", w);
        rd_chk(4, 3, "R5", w);
        chk(wb_cnt == 1 && last_wb == 28'h0001_001, "R4", last_wb, 28'h0001_001);
        chk(l1[1] == gold_line(1), "R5", l1[1], gold_line(1));
        rd_chk(5, 0, "R4", w);
        chk(last_wb == 28'h0001_002, "R4", last_wb, 28'h0001_002);
        rd_chk(6, 0, "R4", w);
        rd_chk(7, 0, "R4", w);
        chk(wb_cnt == 4 && last_wb == 28'h0001_000, "R4", last_wb, 28'h0001_000);
        // R6 clean victim (line 4)
        wb0 = wb_cnt; f0 = fill_cnt;
        rd_chk(8, 2, "R6", w);
        chk(wb_cnt == wb0 && fill_cnt == f0 + 1, "R6", wb_cnt, wb0);

        // R8 flush with nothing dirty
        flush(seen);
        chk(seen && wb_cnt == wb0, "R8", {seen, 8'(wb_cnt)}, {1'b1, 8'(wb0)});
        f0 = fill_cnt;
        rd_chk(8, 2, "R8", w);
        chk(fill_cnt == f0 + 1, "R8", fill_cnt, f0 + 1);

        // R8 flush with dirty lines
        acc(1'b1, 1'b1, 9, 3, 4'b1000, 32'h7700_0000, rd, w);
        acc(1'b1, 1'b1, 10, 0, 4'b0011, 32'h0000_BEEF, rd, w);
        wb0 = wb_cnt;
        flush(seen);
        chk(seen && wb_cnt == wb0 + 2, "R8", wb_cnt, wb0 + 2);
        for (int i = 0; i < 16; i++) chk(l1[i] == gold_line(i), "R8", l1[i], gold_line(i));

        // R9 flush and stack load in the same cycle
        acc(1'b1, 1'b1, 11, 2, 4'hF, 32'hCAFE_F00D, rd, w);
        fork
            flush(seen);
            begin acc(1'b0, 1'b1, 11, 2, 4'h0, 32'h0, rd, w); end
        join
        chk(w > 0 && seen, "R9", w, 1);
        chk(rd == 32'hCAFE_F00D && l1[11][95:64] == 32'hCAFE_F00D, "R9", rd, 32'hCAFE_F00D);

        // random mix, fixed seed
        void'($urandom(32'h5EED));
        for (int n = 0; n < 400; n++) begin
            int ln = $urandom_range(0, 7);
            int wd = $urandom_range(0, 3);
            if ($urandom_range(0, 39) == 0) flush(seen);
            else if ($urandom_range(0, 1) == 0)
                acc(1'b1, 1'b1, ln, wd, 4'($urandom_range(1, 15)), $urandom, rd, w);
            else rd_chk(ln, wd, "R3", w);
        end
        flush(seen);
        for (int i = 0; i < 16; i++) chk(l1[i] == gold_line(i), "R8", l1[i], gold_line(i));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule